// File: doc/BRIEF.md
# Endian-Selectable Byte FIFO Port

This block is the host-facing data port of a serial memory-card link controller. On the transmit side the host writes 16-bit words and the port breaks each one into two bytes. A mode input picks which byte enters the transmit byte queue first. A single-byte flag lets the host push just one byte, taken from the lane that the byte order selects. The serial side drains the transmit queue one byte at a time through a simple pop interface.

On the receive side the serial side pushes bytes into a receive byte queue. Host reads gather one or two of those bytes into a registered 16-bit word, with the lanes placed according to the same byte order. Both queues report empty and full status. A held soft-clear input empties both queues, resets their pointers, and zeroes the read word and a sticky error flag. Any operation that cannot be honoured is dropped and sets that error flag.

Top module: `byte_fifo_port`

## Requirements
- R1: After rst_n is released, host_rdata is 0, tx_empty and rx_empty are 1, and tx_full, rx_full and err are 0.
- R2: In a cycle where soft_clr is 1, both queues are emptied, host_rdata and err are cleared, and every other request in that cycle is ignored.
- R3: A full-word write (host_byte=0) pushes two bytes. With le_mode=0 (big-endian) host_wdata[15:8] goes in first. With le_mode=1 (little-endian) host_wdata[7:0] goes in first.
- R4: A single-byte write (host_byte=1) pushes one byte. It is host_wdata[15:8] when le_mode=0 and host_wdata[7:0] when le_mode=1.
- R5: A full-word read (host_byte=0) pops two receive bytes. From the next clock, host_rdata holds them with the older byte in [15:8] when le_mode=0 and in [7:0] when le_mode=1. host_rdata changes only on an accepted read or a clear.
- R6: A single-byte read (host_byte=1) pops one byte. It goes to [15:8] with [7:0] zero when le_mode=0, and to [7:0] with [15:8] zero when le_mode=1.
- R7: Each queue holds DEPTH bytes (8 by default). tx_empty and rx_empty are 1 exactly when their queue holds no byte. tx_full and rx_full are 1 exactly when their queue holds DEPTH bytes.
- R8: The following requests are ignored and change no queue and no host_rdata: a host write needing more free slots than the transmit queue has, a host read needing more bytes than the receive queue holds, a tx_pop on an empty queue, and an rx_push on a full queue.
- R9: Any request ignored under R8 sets err. err stays 1 until reset or soft_clr.
- R10: tx_byte always shows the oldest transmit byte. A host write and a tx_pop in the same cycle are both honoured when each is allowed by the counts at the start of the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Synchronous clear of both queues, read word and error |
| le_mode | input | 1 | Byte order: 0 big-endian, 1 little-endian |
| host_wr | input | 1 | Host write request |
| host_rd | input | 1 | Host read request |
| host_byte | input | 1 | 1 selects a single-byte transfer for host_wr and host_rd |
| host_wdata | input | 16 | Host write word |
| host_rdata | output | 16 | Registered host read word |
| tx_pop | input | 1 | Serial side takes one transmit byte |
| tx_byte | output | 8 | Oldest transmit byte |
| rx_push | input | 1 | Serial side delivers one receive byte |
| rx_byte | input | 8 | Receive byte to store |
| tx_empty | output | 1 | Transmit queue holds no byte |
| tx_full | output | 1 | Transmit queue holds DEPTH bytes |
| rx_empty | output | 1 | Receive queue holds no byte |
| rx_full | output | 1 | Receive queue holds DEPTH bytes |
| err | output | 1 | Sticky flag for an ignored request |

## Verification
The hardest case to reach is a full-word write that arrives when exactly one transmit slot is free. Because it needs two slots, it must be refused whole, even though a single byte would fit. The stimulus reaches this by mixing two-byte and one-byte writes until seven bytes are queued, then issuing a full-word write and checking that the queue and err behave as required. A matching case fills the receive queue with an odd number of bytes and then asks for a full word after only one byte remains. A write issued together with a pop, and a request issued while soft_clr is high, cover the remaining orderings.

// File: rtl/fifo_port_pkg.sv
package fifo_port_pkg;
   typedef logic [7:0] byte_t;

   typedef struct packed {
      byte_t first;
      byte_t second;
   } byte_pair_t;

   localparam int WORD_W = 16;
endpackage

// File: rtl/byte_ring.sv
module byte_ring
   import fifo_port_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic [1:0]                   push_n,
   input  byte_pair_t                   push_pair,
   input  logic [1:0]                   pop_n,
   output byte_pair_t                   head_pair,
   output logic [$clog2(DEPTH+1)-1:0]   count
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("byte_ring: DEPTH must be a power of two of at least 2");
   end

   byte_t         mem [DEPTH];
   logic [PW-1:0] wptr, rptr;
   logic [PW-1:0] wptr_1, rptr_1;

   assign wptr_1 = wptr + PW'(1);
   assign rptr_1 = rptr + PW'(1);

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic we_a, we_b;
      assign we_a = (push_n != 2'd0) && (wptr == PW'(i));
      assign we_b = (push_n == 2'd2) && (wptr_1 == PW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      mem[i] <= '0;
         else if (clr)    mem[i] <= '0;
         else if (we_a)   mem[i] <= push_pair.first;
         else if (we_b)   mem[i] <= push_pair.second;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else if (clr) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         wptr  <= wptr + PW'(push_n);
         rptr  <= rptr + PW'(pop_n);
         count <= count + CW'(push_n) - CW'(pop_n);
      end
   end

   assign head_pair.first  = mem[rptr];
   assign head_pair.second = mem[rptr_1];

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |-> (32'(count) + 32'(push_n) <= 32'(DEPTH) + 32'(pop_n))); // R8
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |-> (32'(pop_n) <= 32'(count))); // R8
endmodule

// File: rtl/lane_splitter.sv
module lane_splitter
   import fifo_port_pkg::*;
#(
   parameter bit LE_SUPPORT = 1'b1
) (
   input  logic [WORD_W-1:0] word,
   input  logic              le_mode,
   input  logic              single,
   output byte_pair_t        pair,
   output logic [1:0]        n
);
   logic le_eff;

   if (LE_SUPPORT) begin : g_both_orders
      assign le_eff = le_mode;
   end else begin : g_big_only
      logic unused_le;
      assign unused_le = le_mode;
      assign le_eff    = 1'b0;
   end

   always_comb begin
      if (le_eff) begin
         pair.first  = word[7:0];
         pair.second = word[15:8];
      end else begin
         pair.first  = word[15:8];
         pair.second = word[7:0];
      end
      n = single ? 2'd1 : 2'd2;
   end
endmodule

// File: rtl/word_packer.sv
module word_packer
   import fifo_port_pkg::*;
#(
   parameter bit LE_SUPPORT = 1'b1
) (
   input  byte_pair_t        pair,
   input  logic              le_mode,
   input  logic              single,
   output logic [WORD_W-1:0] word
);
   logic  le_eff;
   byte_t lo_second;

   if (LE_SUPPORT) begin : g_both_orders
      assign le_eff = le_mode;
   end else begin : g_big_only
      logic unused_le;
      assign unused_le = le_mode;
      assign le_eff    = 1'b0;
   end

   assign lo_second = single ? 8'h00 : pair.second;

   always_comb begin
      if (le_eff) word = {lo_second, pair.first};
      else        word = {pair.first, lo_second};
   end
endmodule

// File: rtl/byte_fifo_port.sv
module byte_fifo_port
   import fifo_port_pkg::*;
#(
   parameter int DEPTH      = 8,
   parameter bit LE_SUPPORT = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        soft_clr,
   input  logic        le_mode,
   input  logic        host_wr,
   input  logic        host_rd,
   input  logic        host_byte,
   input  logic [15:0] host_wdata,
   output logic [15:0] host_rdata,
   input  logic        tx_pop,
   output logic [7:0]  tx_byte,
   input  logic        rx_push,
   input  logic [7:0]  rx_byte,
   output logic        tx_empty,
   output logic        tx_full,
   output logic        rx_empty,
   output logic        rx_full,
   output logic        err
);
   localparam int CW = $clog2(DEPTH+1);

   byte_pair_t    wr_pair, tx_head, rx_head, rx_in;
   logic [1:0]    wr_n, need_n;
   logic [1:0]    tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
   logic [CW-1:0] tx_cnt, rx_cnt, tx_room;
   logic          wr_ok, rd_ok, pop_ok, push_ok, err_set;
   logic [15:0]   rd_word;

   lane_splitter #(.LE_SUPPORT(LE_SUPPORT)) u_split (
      .word(host_wdata), .le_mode(le_mode), .single(host_byte),
      .pair(wr_pair), .n(wr_n)
   );

   assign need_n  = wr_n;
   assign tx_room = CW'(DEPTH) - tx_cnt;
   assign wr_ok   = host_wr && !soft_clr && (tx_room >= CW'(need_n));
   assign pop_ok  = tx_pop  && !soft_clr && (tx_cnt != '0);
   assign push_ok = rx_push && !soft_clr && (rx_cnt != CW'(DEPTH));
   assign rd_ok   = host_rd && !soft_clr && (rx_cnt >= CW'(need_n));

   assign tx_push_n = wr_ok   ? wr_n   : 2'd0;
   assign tx_pop_n  = pop_ok  ? 2'd1   : 2'd0;
   assign rx_push_n = push_ok ? 2'd1   : 2'd0;
   assign rx_pop_n  = rd_ok   ? need_n : 2'd0;

   assign rx_in.first  = rx_byte;
   assign rx_in.second = 8'h00;

   byte_ring #(.DEPTH(DEPTH)) u_tx_ring (
      .clk(clk), .rst_n(rst_n), .clr(soft_clr),
      .push_n(tx_push_n), .push_pair(wr_pair), .pop_n(tx_pop_n),
      .head_pair(tx_head), .count(tx_cnt)
   );

   byte_ring #(.DEPTH(DEPTH)) u_rx_ring (
      .clk(clk), .rst_n(rst_n), .clr(soft_clr),
      .push_n(rx_push_n), .push_pair(rx_in), .pop_n(rx_pop_n),
      .head_pair(rx_head), .count(rx_cnt)
   );

   word_packer #(.LE_SUPPORT(LE_SUPPORT)) u_pack (
      .pair(rx_head), .le_mode(le_mode), .single(host_byte), .word(rd_word)
   );

   assign err_set = !soft_clr &&
                    ((host_wr && !wr_ok) || (host_rd && !rd_ok) ||
                     (tx_pop && !pop_ok) || (rx_push && !push_ok));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_rdata <= '0;
         err        <= 1'b0;
      end else if (soft_clr) begin
         host_rdata <= '0;
         err        <= 1'b0;
      end else begin
         if (rd_ok)   host_rdata <= rd_word;
         if (err_set) err        <= 1'b1;
      end
   end

   assign tx_byte  = tx_head.first;
   assign tx_empty = (tx_cnt == '0);
   assign tx_full  = (tx_cnt == CW'(DEPTH));
   assign rx_empty = (rx_cnt == '0);
   assign rx_full  = (rx_cnt == CW'(DEPTH));

   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      soft_clr |=> (tx_empty && rx_empty && !err && host_rdata == 16'h0)); // R2
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !soft_clr) |=> err); // R9
   AST_REFUSED_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && !soft_clr && tx_full && !tx_pop) |=> (tx_full && err)); // R8
   AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_rd && !soft_clr) |=> $stable(host_rdata)); // R5
   AST_EMPTY_READ_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !soft_clr && rx_empty && !rx_push) |=> (rx_empty && err && $stable(host_rdata))); // R8
endmodule

// File: tb/sim_byte_fifo_port.sv
module sim_byte_fifo_port;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 8;

   logic        clk = 1'b0;
   logic        rst_n, soft_clr, le_mode, host_wr, host_rd, host_byte;
   logic [15:0] host_wdata, host_rdata;
   logic        tx_pop, rx_push;
   logic [7:0]  tx_byte, rx_byte;
   logic        tx_empty, tx_full, rx_empty, rx_full, err;

   int errs   = 0;
   int checks = 0;
   bit done   = 1'b0;

   logic [7:0]  tx_q[$];
   logic [7:0]  rx_q[$];
   logic        err_m   = 1'b0;
   logic [15:0] rdata_m = 16'h0;

   always #(CLK_PERIOD/2) clk = ~clk;

   byte_fifo_port #(.DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .le_mode(le_mode),
      .host_wr(host_wr), .host_rd(host_rd), .host_byte(host_byte),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .tx_pop(tx_pop), .tx_byte(tx_byte), .rx_push(rx_push), .rx_byte(rx_byte),
      .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty),
      .rx_full(rx_full), .err(err)
   );

   task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_state(input string tag);
      chk(tx_empty == (tx_q.size() == 0), "R7 tx_empty", 16'(tx_empty), 16'(tx_q.size() == 0));
      chk(tx_full == (tx_q.size() == DEPTH), "R7 tx_full", 16'(tx_full), 16'(tx_q.size() == DEPTH));
      chk(rx_empty == (rx_q.size() == 0), "R7 rx_empty", 16'(rx_empty), 16'(rx_q.size() == 0));
      chk(rx_full == (rx_q.size() == DEPTH), "R7 rx_full", 16'(rx_full), 16'(rx_q.size() == DEPTH));
      chk(err == err_m, "R9 err", 16'(err), 16'(err_m));
      chk(host_rdata == rdata_m, tag, host_rdata, rdata_m);
      if (tx_q.size() > 0)
         chk(tx_byte == tx_q[0], tag, 16'(tx_byte), 16'(tx_q[0]));
   endtask

   // Driver: applies one cycle of requests and updates the scoreboard queues.
   task automatic step(input bit wr, input bit bt, input logic [15:0] wd,
                       input bit rd, input bit tp, input bit rp,
                       input logic [7:0] rb, input bit sc, input string tag);
      int tc, rc, need;
      logic [7:0] b0, b1;
      @(negedge clk);
      host_wr = wr; host_byte = bt; host_wdata = wd; host_rd = rd;
      tx_pop = tp; rx_push = rp; rx_byte = rb; soft_clr = sc;
      // Monitor: the byte handed to the serial side matches the queue head.
      if (tp && !sc && tx_q.size() > 0)
         chk(tx_byte == tx_q[0], "R10 pop byte", 16'(tx_byte), 16'(tx_q[0]));
      if (sc) begin
         tx_q.delete(); rx_q.delete(); err_m = 1'b0; rdata_m = 16'h0;
      end else begin
         tc = tx_q.size(); rc = rx_q.size(); need = bt ? 1 : 2;
         if (rd) begin
            if (rc >= need) begin
               b0 = rx_q.pop_front();
               b1 = bt ? 8'h00 : rx_q.pop_front();
               rdata_m = le_mode ? {b1, b0} : {b0, b1};
            end else err_m = 1'b1;
         end
         if (tp) begin
            if (tc >= 1) void'(tx_q.pop_front());
            else err_m = 1'b1;
         end
         if (wr) begin
            if (DEPTH - tc >= need) begin
               if (bt) tx_q.push_back(le_mode ? wd[7:0] : wd[15:8]);
               else if (le_mode) begin tx_q.push_back(wd[7:0]); tx_q.push_back(wd[15:8]); end
               else begin tx_q.push_back(wd[15:8]); tx_q.push_back(wd[7:0]); end
            end else err_m = 1'b1;
         end
         if (rp) begin
            if (rc < DEPTH) rx_q.push_back(rb);
            else err_m = 1'b1;
         end
      end
      @(negedge clk);
      host_wr = 0; host_rd = 0; tx_pop = 0; rx_push = 0; soft_clr = 0;
      check_state(tag);
   endtask

   initial begin
      rst_n = 0; soft_clr = 0; le_mode = 0; host_wr = 0; host_rd = 0;
      host_byte = 0; host_wdata = 0; tx_pop = 0; rx_push = 0; rx_byte = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check_state("R1 reset");

      // Transmit side: both orders, single bytes, fill to seven, refused word
      le_mode = 0; step(1, 0, 16'hA1B2, 0, 0, 0, 8'h00, 0, "R3 big write");
      le_mode = 1; step(1, 0, 16'hC3D4, 0, 0, 0, 8'h00, 0, "R3 little write");
      le_mode = 0; step(1, 1, 16'h5566, 0, 0, 0, 8'h00, 0, "R4 big single");
      le_mode = 1; step(1, 1, 16'h7788, 0, 0, 0, 8'h00, 0, "R4 little single");
      le_mode = 0; step(1, 1, 16'h99AA, 0, 0, 0, 8'h00, 0, "R4 seventh byte");
      step(1, 0, 16'hBBCC, 0, 0, 0, 8'h00, 0, "R8 word with one slot");
      step(1, 1, 16'hDDEE, 0, 0, 0, 8'h00, 0, "R7 fill to full");
      step(1, 1, 16'h1234, 0, 0, 0, 8'h00, 0, "R8 write when full");
      step(1, 0, 16'hF00D, 0, 1, 0, 8'h00, 0, "R10 write with pop on full");
      for (int i = 0; i < DEPTH; i++)
         step(0, 0, 16'h0, 0, 1, 0, 8'h00, 0, "R10 drain");
      step(0, 0, 16'h0, 0, 1, 0, 8'h00, 0, "R8 pop when empty");
      step(1, 0, 16'h4242, 0, 0, 0, 8'h00, 1, "R2 clear ignores write");

      // Transmit side: write and pop together
      step(1, 0, 16'h0102, 0, 0, 0, 8'h00, 0, "R3 refill");
      le_mode = 1; step(1, 0, 16'h0304, 0, 1, 0, 8'h00, 0, "R10 write and pop");
      step(0, 0, 16'h0, 0, 1, 0, 8'h00, 0, "R10 pop");
      step(0, 0, 16'h0, 0, 1, 0, 8'h00, 0, "R10 pop");
      step(0, 0, 16'h0, 0, 1, 0, 8'h00, 0, "R10 pop last");

      // Receive side
      le_mode = 0;
      step(0, 0, 16'h0, 1, 0, 0, 8'h00, 0, "R8 read when empty");
      step(0, 0, 16'h0, 0, 0, 0, 8'h00, 1, "R2 clear error");
      foreach (rx_q[i]) ; // keep queue usage simple
      step(0, 0, 16'h0, 0, 0, 1, 8'h11, 0, "R7 rx push");
      step(0, 0, 16'h0, 0, 0, 1, 8'h22, 0, "R7 rx push");
      step(0, 0, 16'h0, 0, 0, 1, 8'h33, 0, "R7 rx push");
      step(0, 0, 16'h0, 0, 0, 1, 8'h44, 0, "R7 rx push");
      step(0, 0, 16'h0, 0, 0, 1, 8'h55, 0, "R7 rx push");
      step(0, 0, 16'h0, 1, 0, 0, 8'h00, 0, "R5 big read");
      le_mode = 1; step(0, 0, 16'h0, 1, 0, 0, 8'h00, 0, "R5 little read");
      le_mode = 0; step(0, 0, 16'h0, 0, 0, 0, 8'h00, 0, "R5 rdata held");
      step(0, 1, 16'h0, 1, 0, 0, 8'h00, 0, "R6 big single read");
      step(0, 0, 16'h0, 0, 0, 1, 8'h66, 0, "R7 rx push");
      step(0, 0, 16'h0, 1, 0, 0, 8'h00, 0, "R8 word read with one byte");
      le_mode = 1; step(0, 1, 16'h0, 1, 0, 0, 8'h00, 0, "R6 little single read");
      for (int i = 0; i < DEPTH; i++)
         step(0, 0, 16'h0, 0, 0, 1, 8'(8'hA0 + i), 0, "R7 rx fill");
      step(0, 0, 16'h0, 0, 0, 1, 8'hEE, 0, "R8 push when full");
      step(0, 0, 16'h0, 1, 0, 1, 8'hEF, 0, "R5 read with push on full");
      step(0, 0, 16'h0, 1, 0, 1, 8'hF1, 0, "R5 read and push");
      step(0, 0, 16'h0, 1, 0, 0, 8'h00, 1, "R2 clear ignores read");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errs++;
         $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end
endmodule